// File: doc/BRIEF.md
# Load/Store Bus Interface Unit

This unit connects the load/store path of a 32-bit processor core to a 32-bit external memory bus. The core issues one request at a time: read or write, a data size of byte, halfword or word, a signed/unsigned flag for narrow loads, a byte address and the store data. The unit runs one bus cycle with a full-word address, active-low byte enables, an active-low read or write strobe and an address-latch-enable output. It then answers with a one-clock completion pulse and, for loads, the extracted and extended result.

Every bus transfer moves a whole 32-bit word. A narrow access is expressed only through the byte enables. Store data are copied into every lane the item could occupy, so the memory needs no shifter. Byte order is a run-time setting held in a one-bit mode register. Misaligned requests and the reserved size code are refused without touching the bus.

Top module: `ldst_bus_unit`

## Requirements
- R1: After reset (rst_n low) the bus is quiet: bus_ale is 0, bus_rd_n and bus_wr_n are 1, bus_nbe is 4'b1111, rsp_done is 0 and req_ready is 1; the byte order is little-endian.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. For an accepted legal request, bus_ale is 1 from the next clock, with bus_addr holding the request address with its two low bits cleared. rsp_done is a single-clock pulse in the clock after the strobe ends. req_ready is 0 from acceptance until rsp_done has been seen.
- R3: Byte enables are active low, bit k covering bus bits 8k+7..8k. In little-endian mode the byte at address offset k uses lane k; in big-endian mode it uses lane 3-k. A halfword uses the lanes of its two bytes, and a word uses all four lanes.
- R4: During a store, bus_wdata carries the byte replicated four times (size 2'b00), the halfword [15:0] replicated twice (size 2'b01), or the whole word (size 2'b10).
- R5: A load of size 2'b00 or 2'b01 returns the addressed item on rsp_rdata, zero-extended when req_signed is 0 and sign-extended when it is 1. In big-endian mode the byte at the lower address is the more significant one. A word load returns bus_rdata unchanged.
- R6: A halfword at an odd address, or a word at an address that is not a multiple of four, is refused. rsp_done and rsp_err are then both 1 in the clock after acceptance, with no strobe, no bus_ale and no memory change.
- R7: Size code 2'b11 is refused in the same way as a misaligned request.
- R8: A clock with cfg_wr at 1 loads cfg_big into the byte-order register (1 = big-endian). A request uses the byte order held at its acceptance, even if cfg_wr changes it during the transfer.
- R9: Loads drive only bus_rd_n low, and stores drive only bus_wr_n low. The two strobes are never low together, and a strobe is low only while bus_ale is 1.
- R10: rsp_rdata changes only on a completed load. Stores and refused requests leave it unchanged.
- R11: The strobe and bus_ale stay active for exactly 1+WAIT_CYCLES clocks per transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Load the byte-order register |
| cfg_big | input | 1 | New byte order, 1 = big-endian |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_signed | input | 1 | Sign-extend narrow loads |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| rsp_done | output | 1 | Completion pulse |
| rsp_err | output | 1 | Request was refused (valid with rsp_done) |
| rsp_rdata | output | 32 | Last load result |
| bus_addr | output | ADDR_W | Word-aligned bus address |
| bus_nbe | output | 4 | Active-low byte enables |
| bus_wdata | output | 32 | Write data lanes |
| bus_rdata | input | 32 | Read data lanes |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_ale | output | 1 | Address valid |

## Verification
The bench builds the unit with ADDR_W at 32 and WAIT_CYCLES set to 1, so every strobe spans two clocks. With that setting the bench can see that the address, enables and write lanes hold still across a multi-clock strobe. It can also write the byte-order register while a transfer is still in flight and show that the transfer keeps the order it was accepted with. A small lane-addressed memory in the bench answers reads and applies only the enabled write lanes, so each store's lane placement shows up in later loads in both byte orders.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  localparam int LANES  = 4;
  localparam int WORD_W = 8 * LANES;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_XFER = 2'b01,
    ST_DONE = 2'b10
  } seq_state_e;

  typedef struct packed {
    logic       write;
    xfer_size_e size;
    logic       sgn;
    logic       big;
    logic [1:0] ofs;
  } xfer_attr_t;

  // Refusal rule: odd halfword, unaligned word, reserved size code.
  function automatic logic bad_request(input xfer_size_e sz, input logic [1:0] ofs);
    case (sz)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return ofs[0];
      SZ_WORD: return |ofs;
      default: return 1'b1;
    endcase
  endfunction

  // Lane of a single byte: offset k -> k (little) or 3-k (big).
  function automatic logic [1:0] byte_lane(input logic [1:0] ofs, input logic big);
    return big ? ~ofs : ofs;
  endfunction

  // Active-high lane mask of an aligned access.
  function automatic logic [LANES-1:0] lane_mask(input xfer_size_e sz, input logic [1:0] ofs,
                                                 input logic big);
    logic [LANES-1:0] m;
    m = '0;
    case (sz)
      SZ_BYTE: m[byte_lane(ofs, big)] = 1'b1;
      SZ_HALF: begin
        m[byte_lane(ofs, big)]         = 1'b1;
        m[byte_lane(ofs | 2'b01, big)] = 1'b1;
      end
      SZ_WORD: m = '1;
      default: m = '0;
    endcase
    return m;
  endfunction

  // Store image: the item copied into every lane it could occupy.
  function automatic logic [WORD_W-1:0] store_image(input xfer_size_e sz,
                                                    input logic [WORD_W-1:0] d);
    case (sz)
      SZ_BYTE: return {LANES{d[7:0]}};
      SZ_HALF: return {(LANES/2){d[15:0]}};
      default: return d;
    endcase
  endfunction

  // Load extraction and extension from the full bus word.
  function automatic logic [WORD_W-1:0] load_pick(input xfer_size_e sz, input logic sgn,
                                                  input logic [1:0] ofs, input logic big,
                                                  input logic [WORD_W-1:0] word);
    logic [1:0]        base;
    logic [WORD_W-1:0] sh;
    logic [7:0]        b;
    logic [15:0]       h;
    base = (sz == SZ_HALF) ? (big ? (ofs ^ 2'b10) : ofs) : byte_lane(ofs, big);
    sh   = word >> {base, 3'b000};
    b    = sh[7:0];
    h    = sh[15:0];
    case (sz)
      SZ_BYTE: return {{(WORD_W-8){sgn & b[7]}}, b};
      SZ_HALF: return {{(WORD_W-16){sgn & h[15]}}, h};
      default: return word;
    endcase
  endfunction

endpackage

// File: rtl/ldst_req_check.sv
module ldst_req_check
  import ldst_pkg::*;
(
  input  xfer_size_e size,
  input  logic [1:0] ofs,
  output logic       reject
);

  assign reject = bad_request(size, ofs);

endmodule

// File: rtl/ldst_lane_unit.sv
module ldst_lane_unit
  import ldst_pkg::*;
(
  input  xfer_size_e        size,
  input  logic [1:0]        ofs,
  input  logic              big,
  input  logic [WORD_W-1:0] wdata,
  output logic [LANES-1:0]  mask,
  output logic [WORD_W-1:0] image
);

  assign mask  = lane_mask(size, ofs, big);
  assign image = store_image(size, wdata);

endmodule

// File: rtl/ldst_load_unit.sv
module ldst_load_unit
  import ldst_pkg::*;
(
  input  xfer_attr_t        attr,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] value
);

  assign value = load_pick(attr.size, attr.sgn, attr.ofs, attr.big, word);

endmodule

// File: rtl/ldst_bus_seq.sv
module ldst_bus_seq
  import ldst_pkg::*;
#(
  parameter int WAIT_CYCLES = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic reject,
  output logic xfer_active,
  output logic capture,
  output logic done_pulse,
  output logic ready
);

  localparam int CNT_W = (WAIT_CYCLES > 0) ? $clog2(WAIT_CYCLES + 1) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYCLES);
  localparam logic [CNT_W:0]   SPAN = (CNT_W+1)'(WAIT_CYCLES + 1);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q;

  assign xfer_active = (st_q == ST_XFER);
  assign capture     = xfer_active && (cnt_q == LAST);
  assign done_pulse  = (st_q == ST_DONE);
  assign ready       = (st_q == ST_IDLE);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start) st_d = reject ? ST_DONE : ST_XFER;
      ST_XFER: if (capture) st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_XFER && !capture) cnt_q <= cnt_q + 1'b1;
      else                             cnt_q <= '0;
    end
  end

  // Independent run-length counter for the strobe window.
  logic [CNT_W:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run_len <= '0;
    else if (xfer_active) run_len <= run_len + 1'b1;
    else                  run_len <= '0;
  end

  assert_strobe_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_active) |-> run_len == SPAN);

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse && ready);

  assert_xfer_then_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_active) |-> done_pulse);

endmodule

// File: rtl/ldst_bus_unit.sv
module ldst_bus_unit
  import ldst_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WAIT_CYCLES = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_big,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [3:0]        bus_nbe,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic              bus_ale
);

  localparam int WADDR_W = ADDR_W - 2;

  // Byte-order mode register, little-endian after reset.
  logic big_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      big_q <= 1'b0;
    else if (cfg_wr) big_q <= cfg_big;
  end

  xfer_size_e req_sz;
  assign req_sz = xfer_size_e'(req_size);

  logic req_reject;
  ldst_req_check u_chk (
    .size  (req_sz),
    .ofs   (req_addr[1:0]),
    .reject(req_reject)
  );

  logic [LANES-1:0]  req_mask;
  logic [WORD_W-1:0] req_img;
  ldst_lane_unit u_lane (
    .size (req_sz),
    .ofs  (req_addr[1:0]),
    .big  (big_q),
    .wdata(req_wdata),
    .mask (req_mask),
    .image(req_img)
  );

  logic accept, xfer_active, capture, done_evt, ready;
  assign accept = req_valid && ready;

  ldst_bus_seq #(.WAIT_CYCLES(WAIT_CYCLES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .reject     (req_reject),
    .xfer_active(xfer_active),
    .capture    (capture),
    .done_pulse (done_evt),
    .ready      (ready)
  );

  xfer_attr_t         attr_q;
  logic               err_q;
  logic [WADDR_W-1:0] waddr_q;
  logic [LANES-1:0]   mask_q;
  logic [WORD_W-1:0]  img_q;
  logic [WORD_W-1:0]  rdata_q;
  logic [WORD_W-1:0]  load_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attr_q  <= '0;
      err_q   <= 1'b0;
      waddr_q <= '0;
      mask_q  <= '0;
      img_q   <= '0;
    end else if (accept) begin
      attr_q.write <= req_write;
      attr_q.size  <= req_sz;
      attr_q.sgn   <= req_signed;
      attr_q.big   <= big_q;
      attr_q.ofs   <= req_addr[1:0];
      err_q        <= req_reject;
      waddr_q      <= req_addr[ADDR_W-1:2];
      mask_q       <= req_mask;
      img_q        <= req_img;
    end
  end

  ldst_load_unit u_load (
    .attr (attr_q),
    .word (bus_rdata),
    .value(load_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        rdata_q <= '0;
    else if (capture && !attr_q.write) rdata_q <= load_val;
  end

  assign req_ready = ready;
  assign rsp_done  = done_evt;
  assign rsp_err   = done_evt && err_q;
  assign rsp_rdata = rdata_q;
  assign bus_ale   = xfer_active;
  assign bus_addr  = xfer_active ? {waddr_q, 2'b00} : '0;
  assign bus_nbe   = xfer_active ? ~mask_q : '1;
  assign bus_rd_n  = !(xfer_active && !attr_q.write);
  assign bus_wr_n  = !(xfer_active && attr_q.write);
  assign bus_wdata = (xfer_active && attr_q.write) ? img_q : '0;

  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  assert_strobe_in_ale_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wr_n) |-> bus_ale);

  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> bus_nbe == 4'hF && bus_rd_n && bus_wr_n);

  assert_refuse_no_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_reject |=> !bus_ale && rsp_err && rsp_done);

  assert_legal_starts_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !req_reject |=> bus_ale && bus_addr[1:0] == 2'b00 && !req_ready);

  assert_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale && $past(bus_ale) |-> $stable(bus_addr) && $stable(bus_nbe));

  assert_half_two_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale && attr_q.size == SZ_HALF |-> $countones(~bus_nbe) == 2);

  assert_byte_one_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale && attr_q.size == SZ_BYTE |-> $onehot0(~bus_nbe) && bus_nbe != 4'hF);

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done && (rsp_err || attr_q.write) |-> $stable(rsp_rdata));

  assert_zero_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    capture && !attr_q.write && attr_q.size == SZ_BYTE && !attr_q.sgn
      |=> rsp_rdata[31:8] == 24'h0);

endmodule

// File: tb/ldst_bus_unit_bench.sv
module ldst_bus_unit_bench;

  localparam int W = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_big = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_signed = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, rsp_done, rsp_err;
  logic [31:0] rsp_rdata, bus_addr, bus_wdata, bus_rdata;
  logic [3:0]  bus_nbe;
  logic        bus_rd_n, bus_wr_n, bus_ale;

  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 0;
  bit mode_big = 0;

  always #4 clk = ~clk;

  ldst_bus_unit #(.ADDR_W(32), .WAIT_CYCLES(W)) u_ldst_bus_unit (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_big(cfg_big),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .bus_addr(bus_addr), .bus_nbe(bus_nbe),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_ale(bus_ale)
  );

  // Lane-addressed memory: 16 words, only enabled lanes are written.
  logic [31:0] mem [0:15];
  assign bus_rdata = mem[bus_addr[5:2]];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= '0;
    end else if (!bus_wr_n) begin
      for (int l = 0; l < 4; l++)
        if (!bus_nbe[l]) mem[bus_addr[5:2]][8*l +: 8] <= bus_wdata[8*l +: 8];
    end
  end

  task automatic check(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : ((sz == 2'd1) ? 2 : 4);
  endfunction

  function automatic int lane_for(input int pos, input bit big);
    return big ? 3 - pos : pos;
  endfunction

  function automatic logic [3:0] exp_nbe(input logic [1:0] sz, input int ofs, input bit big);
    logic [3:0] m = 4'hF;
    for (int i = 0; i < nbytes(sz); i++) m[lane_for(ofs + i, big)] = 1'b0;
    return m;
  endfunction

  function automatic logic [31:0] exp_load(input logic [31:0] word, input logic [1:0] sz,
                                           input bit sgn, input int ofs, input bit big);
    logic [31:0] v = '0;
    int n = nbytes(sz);
    for (int i = 0; i < n; i++) begin
      if (big) v = (v << 8) | 32'(word[8*lane_for(ofs + i, big) +: 8]);
      else     v = v | (32'(word[8*lane_for(ofs + i, big) +: 8]) << (8 * i));
    end
    if (sgn && n < 4 && v[8*n-1]) v = v | (32'hFFFF_FFFF << (8 * n));
    return v;
  endfunction

  function automatic logic [31:0] exp_store(input logic [31:0] old, input logic [1:0] sz,
                                            input int ofs, input bit big, input logic [31:0] d);
    logic [31:0] w = old;
    int n = nbytes(sz);
    for (int i = 0; i < n; i++)
      w[8*lane_for(ofs + i, big) +: 8] = d[8*(big ? n - 1 - i : i) +: 8];
    return w;
  endfunction

  task automatic set_mode(input bit big);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_big = big;
    @(negedge clk);
    cfg_wr = 1'b0;
    mode_big = big;
  endtask

  // One request with full protocol, lane and result checks.
  task automatic run_op(input bit wr, input logic [1:0] sz, input bit sgn,
                        input logic [31:0] addr, input logic [31:0] data,
                        input bit flip, input string tag);
    bit          bad;
    bit          use_big;
    int          ofs, ale_cnt, waited;
    logic [3:0]  enb, seen_nbe;
    logic [31:0] old_word, old_rd, img, seen_addr, seen_wd, exp_val;
    bit          nbe_ok, addr_ok, strb_ok, wd_ok;
    ofs      = int'(addr[1:0]);
    bad      = (sz == 2'd3) || (sz == 2'd1 && addr[0]) || (sz == 2'd2 && addr[1:0] != 2'd0);
    use_big  = mode_big;
    enb      = exp_nbe(sz, ofs, use_big);
    old_word = mem[addr[5:2]];
    old_rd   = rsp_rdata;
    img      = (sz == 2'd0) ? {4{data[7:0]}} : ((sz == 2'd1) ? {2{data[15:0]}} : data);
    nbe_ok = 1; addr_ok = 1; strb_ok = 1; wd_ok = 1;
    seen_nbe = 4'hF; seen_addr = '0; seen_wd = '0;
    @(negedge clk);
    check(req_ready === 1'b1, {tag, " R2 ready before request"}, 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_signed = sgn;
    req_addr = addr; req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0;
    ale_cnt = 0; waited = 0;
    while (!rsp_done && waited < 16) begin
      if (flip && waited == 0) begin cfg_wr = 1'b1; cfg_big = !use_big; end
      else cfg_wr = 1'b0;
      if (bus_ale) begin
        ale_cnt++;
        if (bus_nbe !== enb) begin nbe_ok = 0; seen_nbe = bus_nbe; end
        if (bus_addr !== {addr[31:2], 2'b00}) begin addr_ok = 0; seen_addr = bus_addr; end
        if (bus_rd_n !== wr || bus_wr_n !== !wr) strb_ok = 0;
        if (wr && bus_wdata !== img) begin wd_ok = 0; seen_wd = bus_wdata; end
      end else if (!bus_rd_n || !bus_wr_n) strb_ok = 0;
      @(negedge clk);
      waited++;
    end
    cfg_wr = 1'b0;
    if (flip) mode_big = !use_big;
    check(rsp_done === 1'b1, {tag, " R2 done seen"}, 32'(rsp_done), 32'd1);
    check(rsp_err === bad, {tag, " R6 error flag"}, 32'(rsp_err), 32'(bad));
    if (bad) begin
      check(ale_cnt == 0 && waited == 0, {tag, " R6 no bus cycle"}, 32'(ale_cnt), 32'd0);
      check(mem[addr[5:2]] === old_word, {tag, " R6 memory untouched"}, mem[addr[5:2]], old_word);
    end else begin
      check(ale_cnt == 1 + W && waited == 1 + W, {tag, " R11 strobe length"},
            32'(ale_cnt), 32'(1 + W));
      check(nbe_ok, {tag, " R3 byte enables"}, 32'(seen_nbe), 32'(enb));
      check(addr_ok, {tag, " R2 bus address"}, seen_addr, {addr[31:2], 2'b00});
      check(strb_ok, {tag, " R9 strobe choice"}, {bus_rd_n, bus_wr_n}, 32'(wr));
    end
    if (wr && !bad) begin
      check(wd_ok, {tag, " R4 write lanes"}, seen_wd, img);
      exp_val = exp_store(old_word, sz, ofs, use_big, data);
      check(mem[addr[5:2]] === exp_val, {tag, " R3 memory lanes"}, mem[addr[5:2]], exp_val);
    end
    if (!wr && !bad) begin
      exp_val = exp_load(old_word, sz, sgn, ofs, use_big);
      check(rsp_rdata === exp_val, {tag, " R5 load data"}, rsp_rdata, exp_val);
    end else begin
      check(rsp_rdata === old_rd, {tag, " R10 result held"}, rsp_rdata, old_rd);
    end
    @(negedge clk);
    check(!rsp_done && req_ready, {tag, " R2 done is one pulse"}, 32'(rsp_done), 32'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(bus_ale === 1'b0 && bus_rd_n === 1'b1 && bus_wr_n === 1'b1,
          "R1 strobes idle", {bus_ale, bus_rd_n, bus_wr_n}, 32'b011);
    check(bus_nbe === 4'hF, "R1 enables high", 32'(bus_nbe), 32'hF);
    check(rsp_done === 1'b0 && req_ready === 1'b1, "R1 handshake idle",
          {rsp_done, req_ready}, 32'b01);
  endtask

  task automatic t_word_le;
    run_op(1, 2'd2, 0, 32'h10, 32'h8A7B_6C5D, 0, "word store");
    run_op(0, 2'd2, 0, 32'h10, 32'h0, 0, "word load");
  endtask

  task automatic t_bytes_le;
    run_op(0, 2'd0, 0, 32'h10, 32'h0, 0, "R8 default little byte0");
    run_op(0, 2'd0, 0, 32'h13, 32'h0, 0, "byte3 unsigned");
    run_op(0, 2'd0, 1, 32'h13, 32'h0, 0, "byte3 signed");
    run_op(0, 2'd0, 1, 32'h11, 32'h0, 0, "byte1 signed");
  endtask

  task automatic t_half_le;
    run_op(1, 2'd1, 0, 32'h32, 32'h1234_BEEF, 0, "half store upper");
    run_op(0, 2'd1, 1, 32'h32, 32'h0, 0, "half signed");
    run_op(0, 2'd1, 0, 32'h32, 32'h0, 0, "half unsigned");
    run_op(0, 2'd2, 0, 32'h30, 32'h0, 0, "word after half");
    run_op(1, 2'd0, 0, 32'h21, 32'h1234_56C3, 0, "byte store lane1");
  endtask

  task automatic t_misalign;
    run_op(0, 2'd1, 0, 32'h11, 32'h0, 0, "odd half load");
    run_op(0, 2'd2, 0, 32'h12, 32'h0, 0, "word at offset 2");
    run_op(1, 2'd2, 0, 32'h13, 32'hDEAD_BEEF, 0, "word store offset 3");
  endtask

  task automatic t_rsvd;
    run_op(1, 2'd3, 0, 32'h10, 32'hFFFF_FFFF, 0, "R7 reserved store");
    run_op(0, 2'd3, 0, 32'h10, 32'h0, 0, "R7 reserved load");
  endtask

  task automatic t_big;
    set_mode(1);
    run_op(0, 2'd0, 0, 32'h10, 32'h0, 0, "R8 big byte0");
    run_op(0, 2'd1, 0, 32'h12, 32'h0, 0, "R8 big half2");
    run_op(0, 2'd1, 1, 32'h10, 32'h0, 0, "R8 big half0 signed");
    run_op(1, 2'd0, 0, 32'h20, 32'h0000_00AA, 0, "R8 big byte store");
    run_op(1, 2'd1, 0, 32'h22, 32'h0000_5566, 0, "R8 big half store");
    run_op(0, 2'd2, 0, 32'h20, 32'h0, 0, "R8 big word");
  endtask

  task automatic t_latch;
    run_op(0, 2'd0, 0, 32'h10, 32'h0, 1, "R8 order held mid transfer");
    check(mode_big == 0, "R8 bench mode now little", 32'(mode_big), 32'd0);
    run_op(0, 2'd0, 0, 32'h10, 32'h0, 0, "R8 little after change");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_word_le();
    t_bytes_le();
    t_half_le();
    t_misalign();
    t_rsvd();
    t_big();
    t_latch();
    repeat (2) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

endmodule